// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. During a cycle the fetch, the operand reads from the register file, the ALU step, the data memory access and the write-back all happen in one combinational pass. The program counter and the register file are updated together on the next rising edge. The instruction set is a small load/store subset:

- register-to-register add, sub, and, or and set-on-less-than;
- load word and store word;
- add-immediate;
- branch-if-equal;
- an absolute jump within the current 256 MB region;
- a jump to an address held in a register.

The instruction memory and the data memory are small word-addressed arrays inside the core. While the core is held in reset, an environment fills both through a debug write port. It then releases reset and observes the results through a register peek port and the program counter output. The main decoder turns the 6-bit opcode into a control word. A second decoding level turns the ALU-operation class into the ALU function, and for register-format instructions it uses the function field. The add-immediate row and the register-jump path reuse the existing datapath and add no new arithmetic.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset holds the program counter at 0 and blocks all register-file and data-memory writes by the core. Debug writes (dbg_sel=0 selects instruction memory, dbg_sel=1 selects data memory, dbg_addr is a word index) take effect during reset.
- R2: An instruction with opcode 0x00 and function field (bits 5..0) 0x20, 0x22, 0x24, 0x25 or 0x2A writes rs+rt, rs-rt, rs&rt, rs|rt, or the signed comparison rs<rt as 1 or 0, into register rd. The rs field is bits 25..21, rt is bits 20..16 and rd is bits 15..11.
- R3: Register 0 always reads as zero, and writes to register 0 have no effect.
- R4: Opcode 0x23 loads the data word at byte address rs + sign-extended bits 15..0 into register rt. The word index is the byte address divided by 4.
- R5: Opcode 0x2B stores register rt to the data word at byte address rs + sign-extended bits 15..0.
- R6: Opcode 0x08 writes rs + sign-extended bits 15..0 into register rt.
- R7: Opcode 0x04 sets the next PC to PC+4+(sign-extended bits 15..0 shifted left by 2) when rs equals rt. Otherwise, and for every other non-jump instruction, the next PC is PC+4.
- R8: Opcode 0x02 sets the next PC to PC+4 bits 31..28, then bits 25..0, then two zero bits.
- R9: Opcode 0x00 with function field 0x08 sets the next PC to the value of register rs and writes no register. This selection takes precedence over the other next-PC sources.
- R10: An opcode outside {0x00, 0x02, 0x04, 0x08, 0x23, 0x2B}, or opcode 0x00 with a function field outside the set above, writes neither a register nor data memory, and the next PC is PC+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dbg_we | input | 1 | Debug memory write strobe |
| dbg_sel | input | 1 | Debug target: 0 instruction memory, 1 data memory |
| dbg_addr | input | DBG_AW (6) | Debug word index |
| dbg_wdata | input | 32 | Debug write data |
| dbg_raddr | input | 5 | Register peek address |
| dbg_rdata | output | 32 | Register peek data |
| pc_o | output | 32 | Current program counter |

## Verification
The bench builds the core with the default 64-word instruction memory and 64-word data memory. With these sizes, programs of a dozen instructions fit alongside a data region. The data region is large enough for a positive offset, a negative offset and a store followed by a load-back to land on distinct words. The 6-bit word index uses byte-address bits 7..2, so the branch, jump and register-jump targets all stay inside the loaded program. Each program ends in a branch-to-self, which lets the final PC be compared exactly.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN  = 32;
    localparam int REG_N = 32;
    localparam int RAW   = $clog2(REG_N);

    typedef enum logic [5:0] {
        OP_RTYPE = 6'h00,
        OP_J     = 6'h02,
        OP_BEQ   = 6'h04,
        OP_ADDI  = 6'h08,
        OP_LW    = 6'h23,
        OP_SW    = 6'h2B
    } opcode_e;

    typedef enum logic [5:0] {
        FN_JR  = 6'h08,
        FN_ADD = 6'h20,
        FN_SUB = 6'h22,
        FN_AND = 6'h24,
        FN_OR  = 6'h25,
        FN_SLT = 6'h2A
    } funct_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } aluop_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alufn_e;

    typedef struct packed {
        logic   reg_dst;
        logic   alu_src;
        logic   mem_to_reg;
        logic   reg_write;
        logic   mem_read;
        logic   mem_write;
        logic   branch;
        logic   jump;
        logic   jump_reg;
        aluop_e alu_op;
    } ctrl_t;

    typedef struct packed {
        logic [5:0]     op;
        logic [RAW-1:0] rs;
        logic [RAW-1:0] rt;
        logic [RAW-1:0] rd;
        logic [4:0]     shamt;
        logic [5:0]     funct;
    } instr_t;

    function automatic logic funct_writes(input logic [5:0] f);
        case (f)
            FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT: return 1'b1;
            default:                               return 1'b0;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = AOP_ADD;
        case (op)
            OP_RTYPE: begin
                ctrl.reg_dst = 1'b1;
                ctrl.alu_op  = AOP_FUNCT;
                if (funct == FN_JR) begin
                    ctrl.jump_reg = 1'b1;
                end else begin
                    ctrl.reg_write = funct_writes(funct);
                end
            end
            OP_LW: begin
                ctrl.alu_src    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.reg_write  = 1'b1;
                ctrl.mem_read   = 1'b1;
            end
            OP_SW: begin
                ctrl.alu_src   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = AOP_SUB;
            end
            OP_ADDI: begin
                ctrl.alu_src   = 1'b1;
                ctrl.reg_write = 1'b1;
            end
            OP_J: begin
                ctrl.jump = 1'b1;
            end
            default: begin
                ctrl.alu_op = AOP_ADD;
            end
        endcase
    end

endmodule

// File: rtl/sc_alu_ctl.sv
module sc_alu_ctl
    import sc_pkg::*;
(
    input  aluop_e     alu_op,
    input  logic [5:0] funct,
    output alufn_e     fn
);

    always_comb begin
        case (alu_op)
            AOP_SUB: fn = ALU_SUB;
            AOP_FUNCT: begin
                case (funct)
                    FN_SUB:  fn = ALU_SUB;
                    FN_AND:  fn = ALU_AND;
                    FN_OR:   fn = ALU_OR;
                    FN_SLT:  fn = ALU_SLT;
                    default: fn = ALU_ADD;
                endcase
            end
            default: fn = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alufn_e       fn,
    output logic [W-1:0] y,
    output logic         zero
);

    logic lt;

    assign lt = $signed(a) < $signed(b);

    always_comb begin
        case (fn)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, lt};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    output logic [W-1:0]  rd1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd3
);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
    assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW    = $clog2(IMEM_WORDS),
    localparam int DAW    = $clog2(DMEM_WORDS),
    localparam int DBG_AW = (IAW > DAW) ? IAW : DAW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_we,
    input  logic              dbg_sel,
    input  logic [DBG_AW-1:0] dbg_addr,
    input  logic [XLEN-1:0]   dbg_wdata,
    input  logic [RAW-1:0]    dbg_raddr,
    output logic [XLEN-1:0]   dbg_rdata,
    output logic [XLEN-1:0]   pc_o
);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] jmp_target;
    instr_t          ins;
    ctrl_t           ctrl;
    alufn_e          fn;
    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic            alu_zero;
    logic [XLEN-1:0] dm_rdata;
    logic [XLEN-1:0] wb_data;
    logic [RAW-1:0]  wb_addr;
    logic            rf_we;
    logic            dm_we;
    logic [DAW-1:0]  dm_idx;

    // Instruction memory: loaded only through the debug port.
    always_ff @(posedge clk) begin
        if (dbg_we && !dbg_sel) begin
            imem[dbg_addr[IAW-1:0]] <= dbg_wdata;
        end
    end

    assign ins = imem[pc_q[IAW+1:2]];

    sc_ctrl u_ctrl (
        .op    (ins.op),
        .funct (ins.funct),
        .ctrl  (ctrl)
    );

    sc_alu_ctl u_alu_ctl (
        .alu_op (ctrl.alu_op),
        .funct  (ins.funct),
        .fn     (fn)
    );

    assign rf_we   = ctrl.reg_write & ~rst;
    assign dm_we   = ctrl.mem_write & ~rst;
    assign wb_addr = ctrl.reg_dst ? ins.rd : ins.rt;

    sc_regfile #(
        .W (XLEN),
        .N (REG_N)
    ) u_rf (
        .clk   (clk),
        .we    (rf_we),
        .waddr (wb_addr),
        .wdata (wb_data),
        .ra1   (ins.rs),
        .rd1   (rs_val),
        .ra2   (ins.rt),
        .rd2   (rt_val),
        .ra3   (dbg_raddr),
        .rd3   (dbg_rdata)
    );

    assign imm_sx = sext16(ins[15:0]);
    assign alu_b  = ctrl.alu_src ? imm_sx : rt_val;

    sc_alu #(
        .W (XLEN)
    ) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .fn   (fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data memory: debug write wins over a core store in the same cycle.
    assign dm_idx = alu_y[DAW+1:2];

    always_ff @(posedge clk) begin
        if (dbg_we && dbg_sel) begin
            dmem[dbg_addr[DAW-1:0]] <= dbg_wdata;
        end else if (dm_we) begin
            dmem[dm_idx] <= rt_val;
        end
    end

    assign dm_rdata = ctrl.mem_read ? dmem[dm_idx] : '0;
    assign wb_data  = ctrl.mem_to_reg ? dm_rdata : alu_y;

    // Next-PC selection: register jump, then absolute jump, then branch.
    assign pc4        = pc_q + 32'd4;
    assign br_target  = pc4 + {imm_sx[XLEN-3:0], 2'b00};
    assign jmp_target = {pc4[XLEN-1:XLEN-4], ins[25:0], 2'b00};

    always_comb begin
        if (ctrl.jump_reg) begin
            pc_next = rs_val;
        end else if (ctrl.jump) begin
            pc_next = jmp_target;
        end else if (ctrl.branch && alu_zero) begin
            pc_next = br_target;
        end else begin
            pc_next = pc4;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        rf_we,
    input logic        dm_we,
    input logic [4:0]  dbg_raddr,
    input logic [31:0] dbg_rdata
);

    logic [31:0] pc_plus4;
    logic [31:0] exp_branch;
    logic [31:0] exp_jump;
    logic        is_beq;
    logic        is_j;
    logic        is_jr;
    logic        op_known;
    logic        fn_known;

    assign pc_plus4   = pc + 32'd4;
    assign exp_branch = pc_plus4 + {{14{instr[15]}}, instr[15:0], 2'b00};
    assign exp_jump   = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign is_beq     = instr[31:26] == 6'h04;
    assign is_j       = instr[31:26] == 6'h02;
    assign is_jr      = (instr[31:26] == 6'h00) && (instr[5:0] == 6'h08);
    assign op_known   = (instr[31:26] == 6'h00) || (instr[31:26] == 6'h02) ||
                        (instr[31:26] == 6'h04) || (instr[31:26] == 6'h08) ||
                        (instr[31:26] == 6'h23) || (instr[31:26] == 6'h2B);
    assign fn_known   = (instr[5:0] == 6'h08) || (instr[5:0] == 6'h20) ||
                        (instr[5:0] == 6'h22) || (instr[5:0] == 6'h24) ||
                        (instr[5:0] == 6'h25) || (instr[5:0] == 6'h2A);

    a_r1_reset_pc: assert property (@(posedge clk) rst |=> pc == 32'd0);

    a_r1_reset_no_write: assert property (@(posedge clk) rst |-> !rf_we && !dm_we);

    a_r3_zero_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (dbg_raddr == 5'd0) |-> (dbg_rdata == 32'd0));

    a_r7_branch_taken: assert property (@(posedge clk) disable iff (rst)
        (is_beq && (rs_val == rt_val)) |=> pc == $past(exp_branch));

    a_r7_branch_not_taken: assert property (@(posedge clk) disable iff (rst)
        (is_beq && (rs_val != rt_val)) |=> pc == $past(pc_plus4));

    a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
        is_j |=> pc == $past(exp_jump));

    a_r9_jr_target: assert property (@(posedge clk) disable iff (rst)
        is_jr |=> pc == $past(rs_val));

    a_r9_jr_no_write: assert property (@(posedge clk) disable iff (rst)
        is_jr |-> !rf_we);

    a_r10_bad_op_no_write: assert property (@(posedge clk) disable iff (rst)
        !op_known |-> !rf_we && !dm_we);

    a_r10_bad_funct_no_write: assert property (@(posedge clk) disable iff (rst)
        ((instr[31:26] == 6'h00) && !fn_known) |-> !rf_we && !dm_we);

endmodule

bind sc_core sc_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pc        (pc_q),
    .instr     (ins),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .rf_we     (rf_we),
    .dm_we     (dm_we),
    .dbg_raddr (dbg_raddr),
    .dbg_rdata (dbg_rdata)
);

// File: tb/tb_sc_core.sv
module tb_sc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dbg_we = 1'b0;
    logic        dbg_sel = 1'b0;
    logic [5:0]  dbg_addr = '0;
    logic [31:0] dbg_wdata = '0;
    logic [4:0]  dbg_raddr = '0;
    logic [31:0] dbg_rdata;
    logic [31:0] pc_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [31:0] prog [16];
    int          plen;

    localparam logic [31:0] HALT = {6'h04, 5'd0, 5'd0, 16'hFFFF};

    always #10 clk = ~clk;

    sc_core dut (
        .clk       (clk),
        .rst       (rst),
        .dbg_we    (dbg_we),
        .dbg_sel   (dbg_sel),
        .dbg_addr  (dbg_addr),
        .dbg_wdata (dbg_wdata),
        .dbg_raddr (dbg_raddr),
        .dbg_rdata (dbg_rdata),
        .pc_o      (pc_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_cmp = n_cmp + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    function automatic logic [31:0] enc_j(int tgt);
        return {6'h02, tgt[25:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp = n_cmp + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic peek(string req, int r, logic [31:0] exp);
        @(negedge clk);
        dbg_raddr = r[4:0];
        #1;
        check(req, dbg_rdata, exp);
    endtask

    task automatic clear_prog();
        plen = 0;
    endtask

    task automatic emit(logic [31:0] w);
        prog[plen] = w;
        plen = plen + 1;
    endtask

    task automatic dbg_put(logic sel, int addr, logic [31:0] w);
        @(negedge clk);
        dbg_we    = 1'b1;
        dbg_sel   = sel;
        dbg_addr  = addr[5:0];
        dbg_wdata = w;
        @(negedge clk);
        dbg_we    = 1'b0;
    endtask

    task automatic load_prog();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < plen; i++) begin
            dbg_put(1'b0, i, prog[i]);
        end
    endtask

    task automatic run(int cycles);
        @(negedge clk);
        rst = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        check("R1 pc in reset", pc_o, 32'd0);
        clear_prog();
        emit(enc_i(6'h08, 0, 13, 16'd1));
        emit(HALT);
        load_prog();
        run(10);
        peek("R1 first run", 13, 32'd1);
        clear_prog();
        emit(enc_i(6'h08, 0, 13, 16'd77));
        emit(HALT);
        load_prog();
        repeat (5) @(negedge clk);
        check("R1 pc held", pc_o, 32'd0);
        peek("R1 no write in reset", 13, 32'd1);
        run(10);
        peek("R1 after release", 13, 32'd77);
    endtask

    task automatic t_arith();
        clear_prog();
        emit(enc_i(6'h08, 0, 1, 16'd7));
        emit(enc_i(6'h08, 0, 2, 16'hFFFD));
        emit(enc_r(1, 2, 3, 6'h20));
        emit(enc_r(1, 2, 4, 6'h22));
        emit(enc_r(1, 2, 5, 6'h24));
        emit(enc_r(1, 2, 6, 6'h25));
        emit(enc_r(2, 1, 7, 6'h2A));
        emit(enc_r(1, 2, 8, 6'h2A));
        emit(HALT);
        load_prog();
        run(20);
        peek("R6 addi positive", 1, 32'd7);
        peek("R6 addi negative", 2, 32'hFFFF_FFFD);
        peek("R2 add", 3, 32'd4);
        peek("R2 sub", 4, 32'd10);
        peek("R2 and", 5, 32'd5);
        peek("R2 or", 6, 32'hFFFF_FFFF);
        peek("R2 slt true signed", 7, 32'd1);
        peek("R2 slt false", 8, 32'd0);
        check("R7 halt pc", pc_o, 32'd32);
    endtask

    task automatic t_zero_reg();
        clear_prog();
        emit(enc_i(6'h08, 0, 0, 16'd5));
        emit(enc_i(6'h08, 0, 1, 16'd9));
        emit(enc_r(1, 1, 0, 6'h20));
        emit(enc_r(0, 0, 9, 6'h25));
        emit(HALT);
        load_prog();
        run(15);
        peek("R3 reg0 reads zero", 0, 32'd0);
        peek("R3 reg0 source zero", 9, 32'd0);
    endtask

    task automatic t_memory();
        clear_prog();
        emit(enc_i(6'h08, 0, 1, 16'd8));
        emit(enc_i(6'h23, 1, 2, 16'd8));
        emit(enc_i(6'h08, 0, 3, 16'h1234));
        emit(enc_i(6'h2B, 1, 3, 16'd12));
        emit(enc_i(6'h23, 0, 4, 16'd20));
        emit(enc_i(6'h08, 0, 5, 16'd40));
        emit(enc_i(6'h23, 5, 6, 16'hFFE8));
        emit(HALT);
        load_prog();
        dbg_put(1'b1, 4, 32'hCAFE_F00D);
        dbg_put(1'b1, 5, 32'h0000_0000);
        run(20);
        peek("R4 load", 2, 32'hCAFE_F00D);
        peek("R5 store then load", 4, 32'h0000_1234);
        peek("R4 load negative offset", 6, 32'hCAFE_F00D);
    endtask

    task automatic t_branch();
        clear_prog();
        emit(enc_i(6'h08, 0, 3, 16'd0));
        emit(enc_i(6'h08, 0, 1, 16'd1));
        emit(enc_i(6'h08, 0, 2, 16'd1));
        emit(enc_i(6'h04, 1, 2, 16'd1));
        emit(enc_i(6'h08, 0, 3, 16'd99));
        emit(enc_i(6'h08, 0, 4, 16'd5));
        emit(enc_i(6'h04, 1, 0, 16'd1));
        emit(enc_i(6'h08, 0, 5, 16'd6));
        emit(HALT);
        load_prog();
        run(25);
        peek("R7 taken branch skips", 3, 32'd0);
        peek("R7 target executes", 4, 32'd5);
        peek("R7 not taken falls through", 5, 32'd6);
        check("R7 backward branch halts", pc_o, 32'd32);
    endtask

    task automatic t_jump();
        clear_prog();
        emit(enc_i(6'h08, 0, 6, 16'd0));
        emit(enc_i(6'h08, 0, 10, 16'd0));
        emit(enc_j(5));
        emit(enc_i(6'h08, 0, 6, 16'd11));
        emit(HALT);
        emit(enc_i(6'h08, 0, 7, 16'd22));
        emit(enc_i(6'h08, 0, 8, 16'd40));
        emit(enc_r(8, 0, 10, 6'h08));
        emit(enc_i(6'h08, 0, 6, 16'd33));
        emit(HALT);
        emit(enc_i(6'h08, 0, 9, 16'd44));
        emit(HALT);
        load_prog();
        run(25);
        peek("R8 jump skips", 6, 32'd0);
        peek("R8 jump target executes", 7, 32'd22);
        peek("R9 register jump target", 9, 32'd44);
        peek("R9 register jump no write", 10, 32'd0);
        check("R9 final pc", pc_o, 32'd44);
    endtask

    task automatic t_illegal();
        clear_prog();
        emit(enc_i(6'h08, 0, 11, 16'd5));
        emit({6'h3F, 5'd0, 5'd11, 16'h0077});
        emit(enc_r(0, 0, 11, 6'h3F));
        emit(enc_i(6'h08, 0, 12, 16'd9));
        emit(HALT);
        load_prog();
        run(15);
        peek("R10 bad opcode no write", 11, 32'd5);
        peek("R10 advance past bad", 12, 32'd9);
        check("R10 final pc", pc_o, 32'd16);
    endtask

    initial begin
        t_reset();
        t_arith();
        t_zero_reg();
        t_memory();
        t_branch();
        t_jump();
        t_illegal();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule